// File: doc/BRIEF.md
# IR Receiver Run-Length Sampler

This block watches the already-demodulated output of a consumer infrared receiver. It samples the line on a slow tick taken from the module clock, and it rejects level changes that do not last long enough. The cleaned level history is turned into one-byte run-length entries. The top bit of each entry is the level and the low seven bits are the run length in samples, minus one. The entries go into a receive FIFO that software drains by reading a data register.

A packet begins only once the line has been active for a programmable time. It ends once the line has stayed idle for a programmable number of sample blocks. At that point the last idle run is flushed into the FIFO and a sticky packet-end flag is set. Three flags can each raise the interrupt line: overflow, packet end and data available. Data available follows the FIFO fill level against a programmable trigger.

Inside the block, the encoder hands each entry to the FIFO as a valid-only stream with no ready signal. The block cannot hold back the infrared line, so an entry offered while the FIFO is full is dropped and flagged rather than stalled.

The register interface is a plain strobe interface:
- Register 0 is control: bit 0 is enable, bit 1 is receive enable, bit 2 is invert.
- Register 1 holds the timing settings: idle count in bits 7:0, filter length in bits 13:8, divider select in bit 16.
- Register 2 holds the activity settings: threshold in bits 7:0, scale in bit 8.
- Register 3 holds the interrupt enables and the trigger level.
- Register 4 is status.
- Register 5 is the data register.

Top module: `ir_rl_rx`

## Requirements
- R1: The sample tick occurs every DIV_FAST clocks when timing bit 16 is 0, and every DIV_SLOW clocks when it is 1. A level held for k ticks is measured as k samples.
- R2: Each FIFO entry holds the run level in bit 7, where 1 means an active pulse, and the run length in samples minus one in bits 6:0.
- R3: With a filter length F in timing bits 13:8, a level change is accepted only after F consecutive samples at the new level, with F=0 treated as 1. A shorter excursion is absorbed into the surrounding run.
- R4: A run longer than 128 samples is emitted as entries with length field 127 (128 samples each), followed by an entry for the remainder.
- R5: Capture starts only once the active level has lasted T+1 samples, where T is activity bits 7:0. When activity bit 8 is set, the requirement becomes (T+1)*ACT_UNIT samples. Runs that complete before capture starts are discarded, while the run in progress when capture starts is kept whole.
- R6: After (N+1)*IDLE_UNIT consecutive idle samples in a packet, where N is timing bits 7:0, the block writes a final idle entry covering those samples, with the length saturating at 127. It then sets the packet-end flag and waits for the next activity.
- R7: Control bit 2 inverts the input line before sampling.
- R8: A write to a full FIFO drops the entry, keeps the fill count at FIFO_DEPTH and sets the overflow flag.
- R9: A read of register 5 returns the oldest entry in bits 7:0 and removes it. A read of an empty FIFO returns 0 and changes nothing.
- R10: The status register holds the following fields, and writing 1 to bit 0 or bit 1 clears that flag while writing 0 leaves it set:
  - bit 0: overflow flag
  - bit 1: packet-end flag
  - bit 4: data available, which is set when the fill count exceeds the trigger level in register 3 bits starting at 8
  - bits starting at 8: the fill count
- R11: The irq output is high when an enabled flag is set. Register 3 bit 0 enables overflow, bit 1 enables packet end and bit 4 enables data available.
- R12: Unless control bits 0 and 1 are both set, no entry is written, the packet-end flag is not set, and the sampler and run counters stay in reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Module clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ir_in | input | 1 | Demodulated infrared line |
| addr | input | 3 | Register select |
| wr_en | input | 1 | Register write strobe |
| wdata | input | 32 | Register write data |
| rd_en | input | 1 | Register read strobe; pops the FIFO when addr is 5 |
| rdata | output | 32 | Register read data, combinational from addr |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds the block with FIFO_DEPTH=8, DIV_FAST=4, DIV_SLOW=8, IDLE_UNIT=4 and ACT_UNIT=4. With these values an idle timeout of N=1 is only eight samples, so each packet closes within a few dozen clocks. A ten-entry burst is enough to overrun the FIFO. A 130-sample pulse that crosses the 128-sample split boundary costs only a few hundred clocks. Both divider settings differ by a factor of two, so the same register programming gives run lengths that show which divider is in force.

// File: rtl/ir_rl_pkg.sv
package ir_rl_pkg;
  localparam int ADDR_W = 3;
  localparam int REG_W  = 32;

  typedef enum logic [ADDR_W-1:0] {
    A_CTRL   = 3'd0,
    A_TIMING = 3'd1,
    A_ACTIVE = 3'd2,
    A_IEN    = 3'd3,
    A_STAT   = 3'd4,
    A_DATA   = 3'd5
  } reg_addr_e;

  // Flag and enable bit positions shared by status and enable registers.
  localparam int B_OVF   = 0;
  localparam int B_PKT   = 1;
  localparam int B_AVAIL = 4;
  localparam int B_LEVEL = 8;

  typedef struct packed {
    logic       level;
    logic [6:0] len;
  } run_entry_t;
endpackage

// File: rtl/ir_rl_tick_filter.sv
module ir_rl_tick_filter #(
  parameter int DIV_FAST = 64,
  parameter int DIV_SLOW = 128
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en,
  input  logic       div_sel,
  input  logic       invert,
  input  logic       ir_in,
  input  logic [5:0] filt_thr,
  output logic       tick,
  output logic       lvl_f
);
  localparam int PW = (DIV_SLOW > 1) ? $clog2(DIV_SLOW) : 1;

  logic [PW-1:0] presc;
  logic [PW-1:0] last;
  logic [1:0]    sync;
  logic [5:0]    gcnt;
  logic          lvl_q;
  logic          smp, diff, accept;

  assign last = div_sel ? PW'(DIV_SLOW - 1) : PW'(DIV_FAST - 1);
  assign tick = en && (presc == last);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             presc <= '0;
    else if (!en || tick)   presc <= '0;
    else                    presc <= presc + PW'(1);
  end

  // Polarity is applied ahead of the synchronizer.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync <= '0;
    else        sync <= {sync[0], ir_in ^ invert};
  end

  assign smp    = sync[1];
  assign diff   = smp != lvl_q;
  assign accept = diff && (({1'b0, gcnt} + 7'd1) >= {1'b0, filt_thr});
  assign lvl_f  = accept ? smp : lvl_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_q <= 1'b0;
      gcnt  <= '0;
    end else if (!en) begin
      lvl_q <= 1'b0;
      gcnt  <= '0;
    end else if (tick) begin
      lvl_q <= lvl_f;
      gcnt  <= (diff && !accept) ? gcnt + 6'd1 : 6'd0;
    end
  end

  AST_TICK_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick); // R1
endmodule

// File: rtl/ir_rl_encoder.sv
module ir_rl_encoder
  import ir_rl_pkg::*;
#(
  parameter int IDLE_UNIT = 128,
  parameter int ACT_UNIT  = 128
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en,
  input  logic       tick,
  input  logic       lvl_f,
  input  logic [7:0] idle_n,
  input  logic [7:0] act_t,
  input  logic       act_scale,
  output logic       push,
  output run_entry_t push_data,
  output logic       pkt_end
);
  localparam int IW = 8 + $clog2(IDLE_UNIT) + 1;
  localparam int AW = 8 + $clog2(ACT_UNIT) + 1;

  logic          run_lvl;
  logic [6:0]    run_len;
  logic          cap_q;
  logic [IW-1:0] idle_cnt;
  logic [AW-1:0] act_cnt;
  logic [IW-1:0] idle_lim;
  logic [AW-1:0] act_req;
  logic          same, roll, idle_hit, start;
  logic [6:0]    len_sat;

  assign idle_lim = (IW'(idle_n) + IW'(1)) * IW'(IDLE_UNIT);
  assign act_req  = (AW'(act_t) + AW'(1)) * (act_scale ? AW'(ACT_UNIT) : AW'(1));
  assign same     = lvl_f == run_lvl;
  assign roll     = same && (run_len == 7'd127);
  assign idle_hit = cap_q && !lvl_f && ((idle_cnt + IW'(1)) == idle_lim);
  assign start    = !cap_q && lvl_f && ((act_cnt + AW'(1)) >= act_req);
  assign len_sat  = (run_len == 7'd127) ? 7'd127 : run_len + 7'd1;

  always_comb begin
    push      = 1'b0;
    push_data = '0;
    pkt_end   = 1'b0;
    if (tick && cap_q) begin
      if (idle_hit) begin
        push      = 1'b1;
        push_data = '{level: 1'b0, len: len_sat};
        pkt_end   = 1'b1;
      end else if (!same) begin
        push      = 1'b1;
        push_data = '{level: run_lvl, len: run_len};
      end else if (roll) begin
        push      = 1'b1;
        push_data = '{level: run_lvl, len: 7'd127};
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_lvl <= 1'b0; run_len <= '0; cap_q <= 1'b0; idle_cnt <= '0; act_cnt <= '0;
    end else if (!en) begin
      run_lvl <= 1'b0; run_len <= '0; cap_q <= 1'b0; idle_cnt <= '0; act_cnt <= '0;
    end else if (tick) begin
      if (idle_hit) begin
        run_lvl <= 1'b0; run_len <= '0; cap_q <= 1'b0; idle_cnt <= '0; act_cnt <= '0;
      end else begin
        if (!same) begin
          run_lvl <= lvl_f;
          run_len <= '0;
        end else if (roll) begin
          run_len <= '0;
        end else begin
          run_len <= run_len + 7'd1;
        end
        idle_cnt <= (cap_q && !lvl_f) ? idle_cnt + IW'(1) : '0;
        if (start) cap_q <= 1'b1;
        if (!lvl_f)                 act_cnt <= '0;
        else if (act_cnt != '1)     act_cnt <= act_cnt + AW'(1);
      end
    end
  end

  AST_IDLE_RETURN: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_end |=> !cap_q); // R6
  AST_QUIET_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !en |-> !push); // R12
endmodule

// File: rtl/ir_rl_fifo.sv
module ir_rl_fifo #(
  parameter int DEPTH = 16,
  parameter int W     = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr,
  input  logic [W-1:0]               wdata,
  input  logic                       rd,
  output logic [W-1:0]               rdata,
  output logic [$clog2(DEPTH+1)-1:0] count,
  output logic                       overflow
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [CW-1:0] cnt;
  logic          full, empty, do_wr, do_rd;

  assign full     = cnt == CW'(DEPTH);
  assign empty    = cnt == '0;
  assign do_rd    = rd && !empty;
  assign do_wr    = wr && (!full || do_rd);
  assign overflow = wr && full && !do_rd;
  assign rdata    = empty ? '0 : mem[rp];
  assign count    = cnt;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (do_wr) mem[wp] <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp <= '0; rp <= '0; cnt <= '0;
    end else begin
      if (do_wr) wp <= bump(wp);
      if (do_rd) rp <= bump(rp);
      case ({do_wr, do_rd})
        2'b10:   cnt <= cnt + CW'(1);
        2'b01:   cnt <= cnt - CW'(1);
        default: cnt <= cnt;
      endcase
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CW'(DEPTH)); // R8
  AST_DROP_KEEPS_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    overflow |=> cnt == CW'(DEPTH)); // R8
  AST_EMPTY_POP: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && empty && !wr) |=> cnt == '0); // R9
endmodule

// File: rtl/ir_rl_rx.sv
module ir_rl_rx
  import ir_rl_pkg::*;
#(
  parameter int FIFO_DEPTH = 16,
  parameter int DIV_FAST   = 64,
  parameter int DIV_SLOW   = 128,
  parameter int IDLE_UNIT  = 128,
  parameter int ACT_UNIT   = 128
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ir_in,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic [REG_W-1:0]  wdata,
  input  logic              rd_en,
  output logic [REG_W-1:0]  rdata,
  output logic              irq
);
  localparam int CW = $clog2(FIFO_DEPTH + 1);

  logic [2:0]    ctl_q;
  logic [7:0]    idle_q;
  logic [5:0]    filt_q;
  logic          sel_q;
  logic [7:0]    act_q;
  logic          scale_q;
  logic          ien_ovf, ien_pkt, ien_av;
  logic [CW-1:0] trig_q;
  logic          ovf_f, pkt_f;

  logic          en, tick, lvl_f, push, pkt_end, pop, fifo_ovf, avail;
  run_entry_t    push_data;
  logic [7:0]    head;
  logic [CW-1:0] fill;
  reg_addr_e     ra;

  assign ra  = reg_addr_e'(addr);
  assign en  = ctl_q[0] && ctl_q[1];
  assign pop = rd_en && (ra == A_DATA);

  ir_rl_tick_filter #(.DIV_FAST(DIV_FAST), .DIV_SLOW(DIV_SLOW)) u_tick (
    .clk(clk), .rst_n(rst_n), .en(en), .div_sel(sel_q), .invert(ctl_q[2]),
    .ir_in(ir_in), .filt_thr(filt_q), .tick(tick), .lvl_f(lvl_f));

  ir_rl_encoder #(.IDLE_UNIT(IDLE_UNIT), .ACT_UNIT(ACT_UNIT)) u_enc (
    .clk(clk), .rst_n(rst_n), .en(en), .tick(tick), .lvl_f(lvl_f),
    .idle_n(idle_q), .act_t(act_q), .act_scale(scale_q),
    .push(push), .push_data(push_data), .pkt_end(pkt_end));

  ir_rl_fifo #(.DEPTH(FIFO_DEPTH), .W(8)) u_fifo (
    .clk(clk), .rst_n(rst_n), .wr(push), .wdata(push_data), .rd(pop),
    .rdata(head), .count(fill), .overflow(fifo_ovf));

  assign avail = fill > trig_q;
  assign irq   = (ovf_f && ien_ovf) || (pkt_f && ien_pkt) || (avail && ien_av);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q <= '0; idle_q <= '0; filt_q <= '0; sel_q <= 1'b0;
      act_q <= '0; scale_q <= 1'b0;
      ien_ovf <= 1'b0; ien_pkt <= 1'b0; ien_av <= 1'b0; trig_q <= '0;
    end else if (wr_en) begin
      case (ra)
        A_CTRL:   ctl_q <= wdata[2:0];
        A_TIMING: begin
          idle_q <= wdata[7:0];
          filt_q <= wdata[13:8];
          sel_q  <= wdata[16];
        end
        A_ACTIVE: begin
          act_q   <= wdata[7:0];
          scale_q <= wdata[8];
        end
        A_IEN: begin
          ien_ovf <= wdata[B_OVF];
          ien_pkt <= wdata[B_PKT];
          ien_av  <= wdata[B_AVAIL];
          trig_q  <= wdata[B_LEVEL +: CW];
        end
        default: ;
      endcase
    end
  end

  logic clr_ovf, clr_pkt;
  assign clr_ovf = wr_en && (ra == A_STAT) && wdata[B_OVF];
  assign clr_pkt = wr_en && (ra == A_STAT) && wdata[B_PKT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ovf_f <= 1'b0;
      pkt_f <= 1'b0;
    end else begin
      ovf_f <= (ovf_f && !clr_ovf) || fifo_ovf;
      pkt_f <= (pkt_f && !clr_pkt) || pkt_end;
    end
  end

  always_comb begin
    rdata = '0;
    case (ra)
      A_CTRL:   rdata[2:0] = ctl_q;
      A_TIMING: begin
        rdata[7:0]  = idle_q;
        rdata[13:8] = filt_q;
        rdata[16]   = sel_q;
      end
      A_ACTIVE: begin
        rdata[7:0] = act_q;
        rdata[8]   = scale_q;
      end
      A_IEN: begin
        rdata[B_OVF]        = ien_ovf;
        rdata[B_PKT]        = ien_pkt;
        rdata[B_AVAIL]      = ien_av;
        rdata[B_LEVEL +: CW] = trig_q;
      end
      A_STAT: begin
        rdata[B_OVF]        = ovf_f;
        rdata[B_PKT]        = pkt_f;
        rdata[B_AVAIL]      = avail;
        rdata[B_LEVEL +: CW] = fill;
      end
      A_DATA:   rdata[7:0] = head;
      default:  rdata = '0;
    endcase
  end

  AST_PKT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (pkt_f && !clr_pkt) |=> pkt_f); // R10
  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_f && !clr_ovf) |=> ovf_f); // R10
  AST_NO_PKT_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !pkt_f) |=> !pkt_f); // R12
endmodule

// File: tb/sim_ir_rl_rx.sv
module sim_ir_rl_rx;
  import ir_rl_pkg::*;

  localparam int DEPTH = 8;
  localparam int CW    = $clog2(DEPTH + 1);

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ir = 1'b0;
  logic [2:0]  addr = '0;
  logic        wr_en = 1'b0;
  logic [31:0] wdata = '0;
  logic        rd_en = 1'b0;
  logic [31:0] rdata;
  logic        irq;

  int nchk = 0;
  int nfail = 0;
  int div_cur = 4;
  int first = 0;
  bit done = 1'b0;
  logic [31:0] s, d;

  always #4 clk = ~clk;

  ir_rl_rx #(.FIFO_DEPTH(DEPTH), .DIV_FAST(4), .DIV_SLOW(8),
             .IDLE_UNIT(4), .ACT_UNIT(4)) u0 (
    .clk(clk), .rst_n(rst_n), .ir_in(ir), .addr(addr), .wr_en(wr_en),
    .wdata(wdata), .rd_en(rd_en), .rdata(rdata), .irq(irq));

  // Row: [15] last of frame, [14] level, [13:8] samples held, [7:0] expected entry.
  localparam int NV = 17;
  localparam logic [15:0] VEC [NV] = '{
    16'h4584, 16'h0302, 16'h4281, 16'h0605, 16'hC382,
    16'h4281, 16'h0504, 16'h4685, 16'h0201, 16'hC281,
    16'h4382, 16'h0302, 16'h4382, 16'h0302, 16'h4382, 16'h0201, 16'hC483
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] v);
    @(negedge clk); addr = a; wdata = v; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] v);
    @(negedge clk); addr = a; rd_en = 1'b1;
    #1 v = rdata;
    @(negedge clk); rd_en = 1'b0;
  endtask

  task automatic drive(input logic lvl, input int n);
    @(negedge clk); ir = lvl;
    repeat (n * div_cur - 1) @(negedge clk);
  endtask

  task automatic expect_entries(input string tag, input int n, input logic [7:0] e0,
                                input logic [7:0] e1, input logic [7:0] e2, input logic [7:0] e3);
    logic [7:0] ex [4];
    ex = '{e0, e1, e2, e3};
    rd(A_STAT, s); chk({tag, " count"}, 32'(s[8 +: CW]), 32'(n));
    for (int k = 0; k < n; k++) begin
      rd(A_DATA, d); chk(tag, d, 32'(ex[k]));
    end
    wr(A_STAT, 32'h3);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nfail++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // Reset state (R10, R11, R9)
    rd(A_STAT, s); chk("R10 reset status", s, 32'h0);
    chk("R11 reset irq", 32'(irq), 32'h0);
    rd(A_DATA, d); chk("R9 empty read", d, 32'h0);
    rd(A_STAT, s); chk("R9 empty read count", s, 32'h0);

    wr(A_TIMING, 32'h0000_0201);   // N=1 -> 8 idle samples, filter 2, fast divider
    wr(A_ACTIVE, 32'h0000_0001);   // capture after 2 active samples
    wr(A_IEN,    32'h0000_0210);   // data available, trigger level 2
    wr(A_CTRL,   32'h3);
    rd(A_CTRL, s); chk("R12 ctrl readback", s, 32'h3);

    // Table-driven frames (R2, R6, R10)
    for (int i = 0; i < NV; i++) begin
      drive(VEC[i][14], int'(VEC[i][13:8]));
      if (VEC[i][15]) begin
        drive(1'b0, 16);
        rd(A_STAT, s);
        chk("R6 pkt flag", 32'(s[1]), 32'h1);
        chk("R10 fill count", 32'(s[8 +: CW]), 32'(i - first + 2));
        for (int j = first; j <= i; j++) begin
          rd(A_DATA, d); chk("R2 entry", d, 32'(VEC[j][7:0]));
        end
        rd(A_DATA, d); chk("R6 final idle entry", d, 32'h07);
        wr(A_STAT, 32'h2);
        rd(A_STAT, s); chk("R10 w1c pkt", 32'(s[1]), 32'h0);
        first = i + 1;
      end
    end

    // Data available and interrupt masking (R10, R11)
    drive(1'b1, 5); drive(1'b0, 3); drive(1'b1, 2); drive(1'b0, 6); drive(1'b1, 3); drive(1'b0, 16);
    chk("R11 irq on avail", 32'(irq), 32'h1);
    rd(A_STAT, s); chk("R10 avail set", 32'(s[4]), 32'h1);
    for (int k = 0; k < 4; k++) rd(A_DATA, d);
    rd(A_STAT, s); chk("R10 avail clear at level", 32'(s[4]), 32'h0);
    chk("R11 irq masked pkt", 32'(irq), 32'h0);
    wr(A_IEN, 32'h0000_0202);
    chk("R11 irq on pkt", 32'(irq), 32'h1);
    wr(A_STAT, 32'h0);
    rd(A_STAT, s); chk("R10 write zero keeps pkt", 32'(s[1]), 32'h1);
    wr(A_STAT, 32'h2);
    chk("R11 irq after clear", 32'(irq), 32'h0);
    rd(A_DATA, d); chk("R9 pop order", d, 32'h82);
    rd(A_DATA, d); chk("R9 pop order", d, 32'h07);

    // Glitch filter (R3): one-sample pulse inside a space is absorbed
    drive(1'b1, 4); drive(1'b0, 3); drive(1'b1, 1); drive(1'b0, 3); drive(1'b1, 3); drive(1'b0, 16);
    expect_entries("R3 glitch", 4, 8'h83, 8'h06, 8'h82, 8'h07);

    // Long run split (R4)
    drive(1'b1, 130); drive(1'b0, 16);
    expect_entries("R4 split", 3, 8'hFF, 8'h81, 8'h07, 8'h00);

    // Activity threshold (R5)
    wr(A_ACTIVE, 32'h0000_0002);
    drive(1'b1, 2); drive(1'b0, 4); drive(1'b1, 4); drive(1'b0, 16);
    expect_entries("R5 threshold", 2, 8'h83, 8'h07, 8'h00, 8'h00);
    wr(A_ACTIVE, 32'h0000_0100);   // (0+1)*4 samples
    drive(1'b1, 3); drive(1'b0, 4); drive(1'b1, 5); drive(1'b0, 16);
    expect_entries("R5 scaled", 2, 8'h84, 8'h07, 8'h00, 8'h00);
    wr(A_ACTIVE, 32'h0000_0001);

    // Slow divider (R1)
    wr(A_TIMING, 32'h0001_0201);
    div_cur = 8;
    drive(1'b1, 5); drive(1'b0, 3); drive(1'b1, 2); drive(1'b0, 16);
    expect_entries("R1 slow divider", 4, 8'h84, 8'h02, 8'h81, 8'h07);
    wr(A_TIMING, 32'h0000_0201);
    div_cur = 4;

    // Inverted polarity (R7)
    wr(A_CTRL, 32'h0);
    @(negedge clk); ir = 1'b1;
    wr(A_CTRL, 32'h7);
    drive(1'b0, 4); drive(1'b1, 3); drive(1'b0, 2); drive(1'b1, 16);
    expect_entries("R7 invert", 4, 8'h83, 8'h02, 8'h81, 8'h07);
    wr(A_CTRL, 32'h0);
    @(negedge clk); ir = 1'b0;
    wr(A_CTRL, 32'h3);

    // Overflow (R8)
    wr(A_IEN, 32'h0000_0201);
    for (int k = 0; k < 4; k++) begin drive(1'b1, 2); drive(1'b0, 2); end
    drive(1'b1, 2); drive(1'b0, 16);
    rd(A_STAT, s);
    chk("R8 ovf flag", 32'(s[0]), 32'h1);
    chk("R8 count held", 32'(s[8 +: CW]), 32'(DEPTH));
    chk("R11 irq on ovf", 32'(irq), 32'h1);
    for (int k = 0; k < DEPTH; k++) begin
      rd(A_DATA, d); chk("R8 kept entry", d, (k % 2 == 0) ? 32'h81 : 32'h01);
    end
    rd(A_DATA, d); chk("R9 empty after drain", d, 32'h0);
    wr(A_STAT, 32'h3);
    rd(A_STAT, s); chk("R10 flags cleared", s, 32'h0);

    // Receive disabled (R12)
    wr(A_CTRL, 32'h1);
    drive(1'b1, 5); drive(1'b0, 3); drive(1'b1, 3); drive(1'b0, 16);
    rd(A_STAT, s); chk("R12 nothing captured", s, 32'h0);
    wr(A_CTRL, 32'h3);
    drive(1'b1, 3); drive(1'b0, 16);
    expect_entries("R12 re-enabled", 2, 8'h82, 8'h07, 8'h00, 8'h00);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule